// File: doc/BRIEF.md
# SIMD-Aware Branch Condition Evaluator

This block decides whether a conditional operation (a branch, a conditional move) is taken. It tests a register value against one of two base conditions: the low bit is set, or the value is zero. Either condition can be inverted. The register is split into lanes of a selectable width, and the condition is evaluated separately for each lane.

In scalar use, only the lowest lane decides the outcome. When the SIMD flag is set, the per-lane results are reduced to a single bit. The "all" reduction takes the operation only if every lane satisfies the condition. The "any" reduction takes it if at least one lane does. The block has no clock and no state, so the decision follows the inputs within the same cycle.

Top module: `simd_cond_eval`

## Requirements
- R1: With `test_zero` = 0, the condition for a lane is true when bit 0 of that lane is 1. A lane of width W starting at bit c*W tests register bit c*W.
- R2: With `test_zero` = 1, the condition for a lane is true when every bit of that lane is 0.
- R3: `negate` = 1 inverts each lane's condition before the lanes are reduced. Under the "all" reduction, for example, the operation is taken only if no lane satisfies the base condition.
- R4: With `simd` = 0, `taken` equals the (possibly inverted) condition of lane 0. Bits above lane 0 and the `need_all` input have no effect.
- R5: With `simd` = 1 and `need_all` = 1, `taken` is 1 exactly when the condition holds in every lane.
- R6: With `simd` = 1 and `need_all` = 0, `taken` is 1 exactly when the condition holds in at least one lane.
- R7: `lane_size` selects the lane width: 00 = 8 bits, 01 = 16 bits, 10 = 32 bits, 11 = 64 bits. Lane c occupies bits c*W to c*W+W-1.
- R8: With 64-bit lanes on the default 64-bit register, there is a single lane. `simd` and `need_all` then have no effect on `taken`.
- R9: The block is purely combinational. `taken` reflects a change on any input without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value | input | DATA_W (64) | Register value under test |
| test_zero | input | 1 | 0 = low-bit condition, 1 = zero condition |
| negate | input | 1 | Invert the per-lane condition |
| need_all | input | 1 | SIMD reduction: 1 = all lanes, 0 = any lane |
| simd | input | 1 | 0 = test lane 0 only, 1 = reduce over all lanes |
| lane_size | input | 2 | Lane width select (8/16/32/64 bits) |
| taken | output | 1 | Operation is taken |

## Verification
The assertions are immediate checks in a checker module. They assume that every input has a known 0/1 value, and they stay silent while any input or the output is unknown. Their claims relate the output to lane 0 and to the whole register for the default 64-bit width only. The bench keeps to that configuration. It drives every input to a defined value before each comparison and settles the inputs between clock edges. It sweeps all 64 control combinations over each value pattern.

// File: rtl/simd_cond_eval.sv
module simd_cond_eval #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] value,
  input  logic              test_zero,
  input  logic              negate,
  input  logic              need_all,
  input  logic              simd,
  input  logic [1:0]        lane_size,
  output logic              taken
);
  localparam int NSIZE = 4;

  logic [NSIZE-1:0] first_hit;
  logic [NSIZE-1:0] any_hit;
  logic [NSIZE-1:0] all_hit;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W = 8 << g;
    localparam int N = DATA_W / W;
    logic [N-1:0] hit;
    for (genvar c = 0; c < N; c++) begin : g_lane
      logic [W-1:0] lane;
      assign lane   = value[c*W +: W];
      assign hit[c] = (test_zero ? ~|lane : lane[0]) ^ negate;
    end
    assign first_hit[g] = hit[0];
    assign any_hit[g]   = |hit;
    assign all_hit[g]   = &hit;
  end

  assign taken = !simd    ? first_hit[lane_size] :
                 need_all ? all_hit[lane_size]   :
                            any_hit[lane_size];
endmodule

// File: rtl/simd_cond_eval_chk.sv
module simd_cond_eval_chk #(
  parameter int DATA_W = 64
) (
  input logic [DATA_W-1:0] value,
  input logic              test_zero,
  input logic              negate,
  input logic              need_all,
  input logic              simd,
  input logic [1:0]        lane_size,
  input logic              taken
);
  logic [DATA_W-1:0] mask0;
  logic              c0;
  int                width;

  always_comb begin
    width = 8 << lane_size;
    if (width >= DATA_W) mask0 = '1;
    else mask0 = ({{(DATA_W-1){1'b0}}, 1'b1} << width) - 1'b1;
    c0 = (test_zero ? ((value & mask0) == '0) : value[0]) ^ negate;
  end

  always_comb begin
    if (!$isunknown({value, test_zero, negate, need_all, simd, lane_size, taken})) begin
      a_r4_scalar_lane0: assert (simd || taken == c0)
        else $error("R4 scalar result differs from lane 0");
      a_r5_all_needs_lane0: assert (!(simd && need_all && taken) || c0)
        else $error("R5 all-reduction taken with lane 0 failing");
      a_r6_any_sees_lane0: assert (!(simd && !need_all && !taken) || !c0)
        else $error("R6 any-reduction not taken with lane 0 passing");
      a_r2_zero_register: assert (!(test_zero && !negate && value == '0) || taken)
        else $error("R2 zero register not taken");
      a_r8_single_wide_lane: assert (lane_size != 2'b11 || DATA_W != 64 || taken == c0)
        else $error("R8 64-bit lane depends on SIMD controls");
    end
  end
endmodule

bind simd_cond_eval simd_cond_eval_chk #(.DATA_W(DATA_W)) u_chk (
  .value(value), .test_zero(test_zero), .negate(negate), .need_all(need_all),
  .simd(simd), .lane_size(lane_size), .taken(taken)
);

// File: tb/simd_cond_eval_tb.sv
module simd_cond_eval_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] value;
  logic        test_zero, negate, need_all, simd;
  logic [1:0]  lane_size;
  logic        taken;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  simd_cond_eval #(.DATA_W(64)) u_dut (
    .value(value), .test_zero(test_zero), .negate(negate), .need_all(need_all),
    .simd(simd), .lane_size(lane_size), .taken(taken)
  );

  function automatic logic model(logic [63:0] v, logic tz, logic ng, logic al,
                                 logic sm, logic [1:0] sz);
    int w = 8 << sz;
    int n = 64 / w;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic any_r = 1'b0;
    logic all_r = 1'b1;
    logic first_r = 1'b0;
    for (int c = 0; c < n; c++) begin
      logic [63:0] lane = (v >> (c * w)) & m;
      logic h = (tz ? (lane == 64'd0) : lane[0]) ^ ng;
      if (c == 0) first_r = h;
      any_r = any_r | h;
      all_r = all_r & h;
    end
    return !sm ? first_r : (al ? all_r : any_r);
  endfunction

  task automatic check(string req, logic exp);
    checks++;
    if (taken !== exp) begin
      errors++;
      $display("FAIL %s value=%h tz=%0b ng=%0b all=%0b simd=%0b size=%0d got=%0b exp=%0b",
               req, value, test_zero, negate, need_all, simd, lane_size, taken, exp);
    end
  endtask

  task automatic apply(logic [63:0] v, logic tz, logic ng, logic al, logic sm, logic [1:0] sz);
    @(negedge clk);
    value = v; test_zero = tz; negate = ng; need_all = al; simd = sm; lane_size = sz;
    #1;
  endtask

  task automatic sweep(logic [63:0] v);
    for (int k = 0; k < 64; k++) begin
      logic [1:0] sz = k[1:0];
      logic sm = k[2];
      logic al = k[3];
      logic ng = k[4];
      logic tz = k[5];
      string req;
      apply(v, tz, ng, al, sm, sz);
      if (sz == 2'b11 && sm) req = "R8";
      else if (!sm) req = "R4";
      else if (al) req = "R5";
      else req = "R6";
      check(req, model(v, tz, ng, al, sm, sz));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    value = '0; test_zero = 0; negate = 0; need_all = 0; simd = 0; lane_size = 2'b00;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // reset state: zero value, low-bit test, scalar -> not taken
    apply(64'd0, 0, 0, 0, 0, 2'b00); check("R1", 1'b0);
    // R1: bit 8 is bit 0 of lane 1 at 8-bit width
    apply(64'h100, 0, 0, 0, 1, 2'b00); check("R1", 1'b1);
    apply(64'h100, 0, 0, 0, 0, 2'b00); check("R4", 1'b0);
    apply(64'h200, 0, 0, 0, 1, 2'b00); check("R1", 1'b0);
    // R2: zero condition per lane
    apply(64'hFF00, 1, 0, 0, 0, 2'b00); check("R2", 1'b1);
    apply(64'hFF00, 1, 0, 0, 0, 2'b01); check("R2", 1'b0);
    // R3: negation before reduction
    apply(64'h0101010101010101, 0, 1, 1, 1, 2'b00); check("R3", 1'b0);
    apply(64'h0101010101010100, 0, 1, 0, 1, 2'b00); check("R3", 1'b1);
    apply(64'h0, 0, 1, 1, 1, 2'b00); check("R3", 1'b1);
    // R7: lane placement for each width
    apply(64'h0000_0001_0000_0000, 0, 0, 0, 1, 2'b10); check("R7", 1'b1);
    apply(64'h0000_0001_0000_0000, 0, 0, 0, 1, 2'b01); check("R7", 1'b1);
    apply(64'h0000_0001_0000_0000, 0, 0, 0, 1, 2'b11); check("R7", 1'b0);
    apply(64'h0000_0000_0001_0000, 0, 0, 1, 1, 2'b01); check("R7", 1'b0);
    // R9: output follows input with no clock edge
    @(negedge clk);
    value = 64'd1; test_zero = 0; negate = 0; simd = 0; lane_size = 2'b00; #1;
    check("R9", 1'b1);
    value = 64'd2; #1;
    check("R9", 1'b0);
    // sweeps
    sweep(64'd0);
    sweep('1);
    sweep(64'h0101010101010101);
    sweep(64'h0001000100010001);
    sweep(64'h0000000100000001);
    sweep(64'h00FF00FF00FF00FF);
    sweep(64'hFF00000000000000);
    for (int b = 0; b < 64; b++) sweep(64'd1 << b);
    r = 64'h9E3779B97F4A7C15;
    for (int i = 0; i < 40; i++) begin
      r = r ^ (r << 13); r = r ^ (r >> 7); r = r ^ (r << 17);
      sweep(r);
      sweep(r & 64'h00FF_0000_FF00_00FF);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule